// File: doc/BRIEF.md
# Multi-Source Reset Controller with Keyed Pin Disable

This block gathers every reset request in a small subsystem into one reset. A board-level reset pin (active low) and six on-chip requests feed it. The on-chip requests are power-on, two supply-voltage monitors, a watchdog, a clock-failure detector and a trimming-data checker. When any of these becomes active, the CPU/peripheral reset turns on at once, with no clock edge needed. Once all requests are gone, the reset is released in step with the clock, after a two-flop synchronizer and a fixed hold count. The warm-up counter reset follows the same signal. A separate output, driven by power-on only, resets the logic that decides whether the pin may act.

A small byte-wide register port sets up the block. A control register holds a pin-disable bit and two spare read/write bits. A change to the pin-disable bit does nothing until a commit key is written to a second address; the bit's value is copied into an applied state only at that moment. The applied state is cleared by power-on alone. The control register itself is cleared by any reset that actually takes effect. A status register keeps one sticky bit per on-chip source and is cleared by writing ones.

Top module: `rstmux_ctrl`

## Requirements
- R1: `sys_rst` goes high in the same cycle, before any clock edge, when `por_req` is high, any bit of `fault_req` is high, or `pin_rst_n` is low while the applied pin-disable state is 0.
- R2: After the last active request goes away, `sys_rst` stays high for at least HOLD_CYC (default 4) rising edges. It falls no later than HOLD_CYC+3 edges after that.
- R3: `wup_rst` always equals `sys_rst`.
- R4: Address 0 is the control register. Bits [2:0] are read/write and come back as written. Bits [7:3] read 0, and writes to them are ignored. Bit 0 is the pin-disable request.
- R5: Writing 1 to control bit 0 does not mask the pin by itself. The pin stays masked only after byte 0xB2 is written to address 1. While masked, a low pin neither resets nor clears the control register.
- R6: A write of any byte other than 0xB2 to address 1 leaves the applied state unchanged. Address 1 reads 0.
- R7: Writing 0 to control bit 0 and then 0xB2 to address 1 lets the pin reset again.
- R8: A pin reset or an on-chip fault reset clears the control register to 0, but leaves the applied pin-disable state unchanged.
- R9: Power-on clears the applied state and the control register. It also sets the status register to 0x01, with only bit 0 set.
- R10: Address 2 is the status register. Bit 0 marks power-on. Bits 1 to 5 mark `fault_req` bits 0 to 4, in this order: voltage monitor 1, voltage monitor 2, watchdog, clock failure, trimming. Bits stay set until a 1 is written to them. Bits 7 and 6 read 0.
- R11: `extcfg_rst` is high exactly while `por_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_req | input | 1 | Power-on reset request, active high |
| pin_rst_n | input | 1 | Board reset pin, active low |
| fault_req | input | 5 | On-chip reset requests: vmon1, vmon2, watchdog, clock fail, trim |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 key, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sys_rst | output | 1 | Combined CPU/peripheral reset |
| wup_rst | output | 1 | Warm-up counter reset |
| extcfg_rst | output | 1 | Reset for the pin-enable logic |

## Verification
The hardest state to reach is one where the applied disable bit and the control register disagree. In that state the pin is masked but the control register reads 0, because a fault reset has wiped the register copy. The stimulus sets the mask with the key, fires each fault source in turn, and then pulls the pin low. A reset at that point would show that the applied state was lost. A random phase mixes control writes, good and bad keys, fault pulses and pin probes, and compares them against a bench model of the register, the applied state and the status bits.

// File: rtl/rstmux_pkg.sv
package rstmux_pkg;
    localparam int NUM_FAULT = 5;
    localparam int NUM_STAT  = NUM_FAULT + 1;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int CTRL_W    = 3;
    localparam logic [DATA_W-1:0] COMMIT_KEY = 8'hB2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_KEY  = 2'd1,
        A_STAT = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic aux_hi;
        logic aux_lo;
        logic ext_off;
    } ctrl_t;

    typedef struct packed {
        logic                 por;
        logic                 pin;
        logic [NUM_FAULT-1:0] fault;
    } req_t;

    function automatic logic [DATA_W-1:0] ctrl_view(ctrl_t c);
        return {{(DATA_W-CTRL_W){1'b0}}, c};
    endfunction

    function automatic logic [DATA_W-1:0] stat_view(logic [NUM_STAT-1:0] s);
        return {{(DATA_W-NUM_STAT){1'b0}}, s};
    endfunction
endpackage

// File: rtl/rstmux_merge.sv
module rstmux_merge
    import rstmux_pkg::*;
(
    input  logic                 por_req,
    input  logic                 pin_rst_n,
    input  logic [NUM_FAULT-1:0] fault_req,
    input  logic                 ext_off_applied,
    output req_t                 req,
    output logic                 req_any
);
    always_comb begin
        req.por   = por_req;
        req.pin   = ~pin_rst_n & ~ext_off_applied;
        req.fault = fault_req;
        req_any   = req.por | req.pin | (|req.fault);
    end
endmodule

// File: rtl/rstmux_regs.sv
module rstmux_regs
    import rstmux_pkg::*;
(
    input  logic                 clk,
    input  req_t                 req,
    input  logic                 req_any,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output ctrl_t                ctrl_q,
    output logic                 ext_off_applied,
    output logic [NUM_STAT-1:0]  stat_q
);
    reg_addr_e            sel;
    logic                 wr_ctrl, wr_key, wr_stat;
    logic [NUM_STAT-1:0]  stat_nxt;

    assign sel     = reg_addr_e'(bus_addr);
    assign wr_ctrl = bus_wr && (sel == A_CTRL);
    assign wr_key  = bus_wr && (sel == A_KEY) && (bus_wdata == COMMIT_KEY);
    assign wr_stat = bus_wr && (sel == A_STAT);

    // Register copy: wiped by any reset that takes effect.
    always_ff @(posedge clk) begin
        if (req_any)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    // Applied state: only power-on clears it; only the key loads it.
    always_ff @(posedge clk) begin
        if (req.por)
            ext_off_applied <= 1'b0;
        else if (wr_key)
            ext_off_applied <= ctrl_q.ext_off;
    end

    always_comb begin
        stat_nxt = stat_q;
        if (wr_stat)
            stat_nxt = stat_nxt & ~bus_wdata[NUM_STAT-1:0];
        stat_nxt[NUM_STAT-1:1] = stat_nxt[NUM_STAT-1:1] | req.fault;
    end

    always_ff @(posedge clk) begin
        if (req.por)
            stat_q <= {{(NUM_STAT-1){1'b0}}, 1'b1};
        else
            stat_q <= stat_nxt;
    end

    always_comb begin
        unique case (sel)
            A_CTRL:  bus_rdata = ctrl_view(ctrl_q);
            A_STAT:  bus_rdata = stat_view(stat_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rstmux_stretch.sv
module rstmux_stretch #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic req_any,
    output logic rst_out
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC);

    logic [1:0]    sync_q;
    logic [CW-1:0] hold_q;

    always_ff @(posedge clk or posedge req_any) begin
        if (req_any)
            sync_q <= 2'b11;
        else
            sync_q <= {sync_q[0], 1'b0};
    end

    always_ff @(posedge clk or posedge req_any) begin
        if (req_any)
            hold_q <= HOLD_LD;
        else if (sync_q[1])
            hold_q <= HOLD_LD;
        else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
    end

    assign rst_out = sync_q[1] | (hold_q != '0);
endmodule

// File: rtl/rstmux_ctrl.sv
module rstmux_ctrl
    import rstmux_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic                 clk,
    input  logic                 por_req,
    input  logic                 pin_rst_n,
    input  logic [NUM_FAULT-1:0] fault_req,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 sys_rst,
    output logic                 wup_rst,
    output logic                 extcfg_rst
);
    req_t                req;
    logic                req_any;
    logic                ext_off_applied;
    ctrl_t               ctrl_q;
    logic [NUM_STAT-1:0] stat_q;

    rstmux_merge u_merge (
        .por_req         (por_req),
        .pin_rst_n       (pin_rst_n),
        .fault_req       (fault_req),
        .ext_off_applied (ext_off_applied),
        .req             (req),
        .req_any         (req_any)
    );

    rstmux_regs u_regs (
        .clk             (clk),
        .req             (req),
        .req_any         (req_any),
        .bus_wr          (bus_wr),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .ctrl_q          (ctrl_q),
        .ext_off_applied (ext_off_applied),
        .stat_q          (stat_q)
    );

    rstmux_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
        .clk     (clk),
        .req_any (req_any),
        .rst_out (sys_rst)
    );

    assign wup_rst    = sys_rst;
    assign extcfg_rst = por_req;
endmodule

// File: rtl/rstmux_chk.sv
module rstmux_chk
    import rstmux_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input logic                 clk,
    input logic                 por_req,
    input logic [NUM_FAULT-1:0] fault_req,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 sys_rst,
    input logic                 wup_rst,
    input logic                 extcfg_rst,
    input logic                 req_any,
    input logic                 ext_off_applied,
    input ctrl_t                ctrl_q,
    input logic [NUM_STAT-1:0]  stat_q
);
    logic [7:0] quiet_q;
    logic       key_ok;

    always_ff @(posedge clk) begin
        if (req_any)
            quiet_q <= '0;
        else if (quiet_q != 8'hFF)
            quiet_q <= quiet_q + 1'b1;
    end

    assign key_ok = bus_wr && (bus_addr == A_KEY) && (bus_wdata == COMMIT_KEY);

    // R1
    fault_hits_rst_chk: assert property (@(posedge clk) disable iff (por_req)
        (|fault_req) |-> sys_rst);

    // R2
    hold_min_chk: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> (quiet_q >= 8'(HOLD_CYC)));

    // R2
    hold_max_chk: assert property (@(posedge clk) disable iff (por_req)
        (quiet_q == 8'(HOLD_CYC + 3)) |-> !sys_rst);

    // R3
    wup_follow_chk: assert property (@(posedge clk) disable iff (por_req)
        wup_rst == sys_rst);

    // R6
    applied_keep_chk: assert property (@(posedge clk) disable iff (por_req)
        !key_ok |=> $stable(ext_off_applied));

    // R9
    por_clear_chk: assert property (@(posedge clk) disable iff (por_req)
        $fell(extcfg_rst) |-> (!ext_off_applied && ctrl_q == '0 && stat_q[0]));

    // R10
    stat_set_chk: assert property (@(posedge clk) disable iff (por_req)
        (|fault_req) |=> ((stat_q[NUM_STAT-1:1] & $past(fault_req)) == $past(fault_req)));
endmodule

bind rstmux_ctrl rstmux_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (.*);

// File: tb/rstmux_ctrl_test.sv
module rstmux_ctrl_test;
    logic       clk = 1'b0;
    logic       por_req, pin_rst_n, bus_wr;
    logic [4:0] fault_req;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       sys_rst, wup_rst, extcfg_rst;

    int total = 0, bad = 0;
    bit done = 0;
    logic [2:0] m_ctrl;
    logic       m_appl;
    logic [5:0] m_stat;

    always #2 clk = ~clk;

    rstmux_ctrl uut (.*);

    function automatic logic [7:0] exp_ctrl_rd(logic [2:0] c);
        return {5'b0, c};
    endfunction

    function automatic logic [7:0] exp_stat_rd(logic [5:0] s);
        return {2'b0, s};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic settle;
        repeat (12) tick();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic key(logic [7:0] d);
        wr(2'd1, d);
        if (d == 8'hB2) m_appl = m_ctrl[0];
    endtask

    task automatic probe_pin(string tag);
        logic hit;
        pin_rst_n = 1'b0; #1; hit = sys_rst;
        check(hit == !m_appl, tag, hit, !m_appl);
        tick(); pin_rst_n = 1'b1; settle();
        if (!m_appl) m_ctrl = '0;
    endtask

    task automatic pulse_fault(int i);
        fault_req[i] = 1'b1; #1;
        check(sys_rst == 1'b1, "R1 fault asserts sys_rst", sys_rst, 1);
        tick(); fault_req = '0; settle();
        m_ctrl = '0; m_stat[i+1] = 1'b1;
    endtask

    task automatic cmp_regs(string tag);
        logic [7:0] v;
        rd(2'd0, v); check(v == exp_ctrl_rd(m_ctrl), {tag, " ctrl"}, v, exp_ctrl_rd(m_ctrl));
        rd(2'd2, v); check(v == exp_stat_rd(m_stat), {tag, " stat"}, v, exp_stat_rd(m_stat));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int cnt;
        void'($urandom(32'd4242));
        por_req = 1'b1; pin_rst_n = 1'b1; fault_req = '0;
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) tick();
        check(sys_rst == 1'b1, "R1 por asserts", sys_rst, 1);
        check(wup_rst == 1'b1, "R3 wup on por", wup_rst, 1);
        check(extcfg_rst == 1'b1, "R11 extcfg high", extcfg_rst, 1);
        por_req = 1'b0; #1;
        check(extcfg_rst == 1'b0, "R11 extcfg low", extcfg_rst, 0);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (sys_rst) cnt++;
            check(wup_rst == sys_rst, "R3 wup tracks", wup_rst, sys_rst);
        end
        check(cnt >= 4 && cnt <= 7, "R2 hold length", cnt, 5);
        m_ctrl = '0; m_appl = 1'b0; m_stat = 6'h01;
        cmp_regs("R9 after por");
        rd(2'd1, v); check(v == 8'h00, "R6 key reads 0", v, 0);

        // R4 directed and random
        wr(2'd0, 8'hFF); m_ctrl = 3'h7; cmp_regs("R4 all ones");
        for (int k = 0; k < 8; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            wr(2'd0, d); m_ctrl = d[2:0];
            cmp_regs("R4 random");
        end

        // R5: disable without key has no effect; pin reset clears copy (R8)
        wr(2'd0, 8'h01); m_ctrl = 3'h1;
        probe_pin("R5 unkeyed pin resets");
        cmp_regs("R8 pin reset clears ctrl");
        wr(2'd0, 8'h01); m_ctrl = 3'h1;
        key(8'hB2);
        probe_pin("R5 keyed pin masked");
        cmp_regs("R5 masked pin keeps ctrl");

        // R6: wrong keys leave the mask
        wr(2'd0, 8'h00); m_ctrl = 3'h0;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if (d == 8'hB2) d = 8'hB3;
            key(d);
        end
        probe_pin("R6 bad keys ignored");

        // R8 / R10: each fault keeps the mask, clears ctrl, sets its bit
        for (int i = 0; i < 5; i++) begin
            wr(2'd2, 8'h3F); m_stat = '0;
            wr(2'd0, 8'h06); m_ctrl = 3'h6;
            pulse_fault(i);
            cmp_regs("R10 fault bit / R8 ctrl clear");
            probe_pin("R8 mask survives fault");
            wr(2'd2, 8'(1 << (i + 1))); m_stat[i+1] = 1'b0;
            cmp_regs("R10 write-one clear");
        end

        // R7: unmask with key
        wr(2'd0, 8'h00); m_ctrl = 3'h0; key(8'hB2);
        probe_pin("R7 pin re-enabled");

        // R9: por clears applied state
        wr(2'd0, 8'h01); m_ctrl = 3'h1; key(8'hB2);
        wr(2'd2, 8'h3F); m_stat = '0;
        pulse_fault(2);
        wr(2'd0, 8'h05); m_ctrl = 3'h5;
        por_req = 1'b1; tick(); tick(); por_req = 1'b0; settle();
        m_ctrl = '0; m_appl = 1'b0; m_stat = 6'h01;
        cmp_regs("R9 por clears");
        probe_pin("R9 por unmasks pin");

        // random mix
        for (int k = 0; k < 40; k++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    wr(2'd0, d); m_ctrl = d[2:0];
                end
                1: key(($urandom % 2) ? 8'hB2 : 8'($urandom));
                2: pulse_fault(int'($urandom % 5));
                default: probe_pin("R5 random pin probe");
            endcase
            cmp_regs("R8 random model");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule